// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write an 8-bit register file of up to 256 entries. A fast system clock samples SCL and SDA, so the block has no clock domain of its own on the bus side. Both lines pass through a synchronizer and a run-length glitch filter. The filtered lines feed edge detection and START/STOP detection. A strap input picks one of two 7-bit device addresses.

A write transaction works as follows. The first byte after a matching write address loads an internal register pointer. Each further byte goes to the register the pointer names, and the pointer then advances by one. To read, the master first writes the pointer. It then issues a repeated START and the read address. The block returns bytes from the pointer and advances the pointer after each byte, until the master answers with NACK.

The register file sits outside the block. The block drives the pointer as the register address, gives a one-cycle write strobe with data, and takes read data back combinationally. SDA is only ever pulled low, through an enable output.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges a device address byte whose upper seven bits equal 0x16 when `addr_sel` is 0, or 0x17 when `addr_sel` is 1. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R2: A device address that does not match gets no acknowledge. Every later byte up to the next START is also ignored: it gets no acknowledge and causes no register write.
- R3: In a write transaction, the first byte after the address is acknowledged and loads the pointer. The pointer appears on `reg_addr`.
- R4: Each later written byte is acknowledged. It produces a single-cycle `reg_wr_en` pulse carrying the byte and the current pointer. After the acknowledge bit the pointer increments by one.
- R5: After a repeated START with the read address, the block sends bytes MSB first, starting at the register the pointer names. The pointer advances by one after each byte sent.
- R6: When the master answers a read byte with NACK, the block releases SDA (`sda_oe` = 0) and sends nothing more.
- R7: A STOP at any point returns the block to idle. A byte clocked after a STOP and without a new START is not acknowledged.
- R8: The pointer wraps from 0xFF to 0x00 during both writes and reads.
- R9: After synchronous active-low reset, `sda_oe` = 0, `reg_wr_en` = 0 and `reg_addr` = 0x00.
- R10: A pulse on either bus line shorter than FILT_LEN system clocks is filtered out. Such an SDA pulse while SCL is high is not taken as a START.
- R11: The block changes the level it drives on SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel | input | 1 | Strap selecting device address 0x16 (0) or 0x17 (1) |
| reg_addr | output | 8 | Register pointer, used as the register file address |
| reg_wr_en | output | 1 | One-cycle write strobe to the register file |
| reg_wr_data | output | 8 | Byte to be written |
| reg_rd_data | input | 8 | Contents of the register at `reg_addr` |

## Verification
Suppose the byte state machine falls out of step with the bus, for example by miscounting bits. The master then sees the acknowledge or read data one bit late, and that shows up within the same byte. A wrong pointer shows up as read-back data that does not match what was written. It also shows up in the bench's register model one transaction later, at the burst that crosses 0xFF. A lost return to idle shows up on the next stray byte after a STOP, a failed address match or a filtered glitch, because that byte would be acknowledged.

// File: rtl/i2c_regslave_pkg.sv
// Package: shared types and constants for the I2C register-access slave.
// Assumes byte-wide registers and an 8-bit register pointer.
package i2c_regslave_pkg;
    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } slv_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Module: i2c_line_filter
// Synchronizes one open-drain bus line into clk and passes a new level on
// only after it has held for FILT_LEN consecutive samples.
// Assumes SYNC_STAGES >= 2 and FILT_LEN >= 1; the idle line level is high.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Count how long the synced level has differed from the output; adopt it once stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= 1'b1;
            run_q  <= '0;
        end else if (synced == line_o) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            line_o <= synced;
            run_q  <= '0;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
// Module: i2c_bus_events
// Derives SCL edges and START/STOP conditions from the filtered lines.
// Assumes SCL and SDA never change in the same clk cycle after filtering.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_regslave.sv
// Module: i2c_regslave
// I2C slave that gives byte access to an external register file through an
// auto-incrementing pointer. Device address = {DEV_ADDR_HI, addr_sel}.
// Assumes clk is at least ~20x SCL, so that filter latency stays well inside
// one SCL phase. Has no clock stretching, general call or 10-bit addressing.
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [5:0] DEV_ADDR_HI = 6'h0B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic        addr_sel,
    output logic [7:0]  reg_addr,
    output logic        reg_wr_en,
    output logic [7:0]  reg_wr_data,
    input  logic [7:0]  reg_rd_data
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              scl_f, sda_f;
    logic              scl_rise, scl_fall, start_evt, stop_evt;

    slv_state_t            state;
    logic [BYTE_W-1:0]     shreg;
    logic [BITCNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]     ptr;
    logic                  rw;
    logic                  byte_done;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2c_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    assign byte_done   = scl_fall && (bitcnt == BITCNT_W'(BYTE_W));
    assign reg_addr    = ptr;
    assign reg_wr_data = shreg;

    // Byte-level protocol engine: receive, acknowledge, transmit, move the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            sda_oe    <= 1'b0;
            reg_wr_en <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            if (stop_evt) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_evt) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_REG, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_f};
                            bitcnt <= bitcnt + BITCNT_W'(1);
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel}) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end else if (state == ST_REG) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                state  <= ST_REG_ACK;
                            end else begin
                                reg_wr_en <= 1'b1;
                                sda_oe    <= 1'b1;
                                state     <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                shreg  <= reg_rd_data;
                                sda_oe <= ~reg_rd_data[BYTE_W-1];
                                state  <= ST_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_REG;
                            end
                        end
                    end
                    ST_REG_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 8'd1;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + BITCNT_W'(1);
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 8'd1;
                            state  <= ST_RACK;
                        end else if (scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && sda_f) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            shreg  <= reg_rd_data;
                            sda_oe <= ~reg_rd_data[BYTE_W-1];
                            state  <= ST_RDAT;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regslave_chk.sv
// Module: i2c_regslave_chk
// Protocol checks for i2c_regslave, attached with bind below.
// Assumes the raw SCL input is steady for several clk cycles around each edge.
module i2c_regslave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic start_evt,
    input logic stop_evt
);
    // R11
    sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R4
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R4
    wr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> sda_oe);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R7
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_wr_en(reg_wr_en),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
);

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_oe, reg_wr_en;
    logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
    logic       sda_line;
    logic [7:0] mem [0:255];
    int         n_run = 0, n_fail = 0, n_wr = 0;
    logic       done = 1'b0;

    // Each entry: {addr_sel, pointer, first byte, second byte}
    localparam logic [24:0] VEC [4] = '{
        {1'b0, 8'h10, 8'h3C, 8'hC3},
        {1'b1, 8'h7F, 8'h01, 8'hFE},
        {1'b0, 8'hFF, 8'h55, 8'hAA},
        {1'b1, 8'h00, 8'h99, 8'h66}
    };

    always #10 clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_rd_data = mem[reg_addr];

    i2c_regslave u_i2c_regslave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
        end else if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
            n_wr <= n_wr + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
        end
        sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        int         wr0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 sda_oe", sda_oe, 0);
        chk("R9 reg_wr_en", reg_wr_en, 0);
        chk("R9 reg_addr", reg_addr, 0);

        // Table walk: write two bytes, then read them back via repeated START
        foreach (VEC[k]) begin
            logic       sel;
            logic [7:0] p, d0, d1;
            {sel, p, d0, d1} = VEC[k];
            addr_sel = sel; wq();
            wr0 = n_wr;
            bus_start();
            send_byte({6'h0B, sel, 1'b0}, ack); chk("R1 write address ack", ack, 1);
            send_byte(p, ack);                  chk("R3 pointer byte ack", ack, 1);
            chk("R3 pointer loaded", reg_addr, p);
            send_byte(d0, ack);                 chk("R4 data0 ack", ack, 1);
            send_byte(d1, ack);                 chk("R4 data1 ack", ack, 1);
            bus_stop();
            chk("R4 write count", n_wr - wr0, 2);
            chk("R4 mem[p]", mem[p], d0);
            chk("R8 mem[p+1]", mem[8'(p + 8'd1)], d1);
            bus_start();
            send_byte({6'h0B, sel, 1'b0}, ack);
            send_byte(p, ack);
            bus_start();
            send_byte({6'h0B, sel, 1'b1}, ack); chk("R1 read address ack", ack, 1);
            recv_byte(1'b1, rd);                chk("R5 read byte0", rd, d0);
            recv_byte(1'b0, rd);                chk("R5 R8 read byte1", rd, d1);
            chk("R6 released after NACK", sda_oe, 0);
            chk("R5 pointer advanced", reg_addr, 8'(p + 8'd2));
            bus_stop();
        end

        // R2: wrong address ignored until next START
        addr_sel = 1'b0; wq();
        wr0 = n_wr;
        bus_start();
        send_byte(8'h2E, ack); chk("R2 mismatch no ack", ack, 0);
        send_byte(8'h20, ack); chk("R2 later byte no ack", ack, 0);
        send_byte(8'h77, ack); chk("R2 later byte no ack", ack, 0);
        chk("R2 no writes", n_wr - wr0, 0);
        bus_stop();

        // R7: STOP mid-transaction returns to idle
        wr0 = n_wr;
        bus_start();
        send_byte(8'h2C, ack);
        send_byte(8'h40, ack);
        bus_stop();
        scl_m = 1'b0; wq();
        send_byte(8'h12, ack); chk("R7 byte after stop no ack", ack, 0);
        send_byte(8'h2C, ack); chk("R7 address after stop no ack", ack, 0);
        chk("R7 no writes", n_wr - wr0, 0);
        chk("R7 mem untouched", mem[8'h40], 8'h40 ^ 8'hA5);
        scl_m = 1'b1; wq();
        bus_stop();

        // R10: a one-clock SDA low pulse with SCL high is not a START
        wq();
        @(negedge clk); sda_m = 1'b0;
        @(negedge clk); sda_m = 1'b1;
        wq();
        scl_m = 1'b0; wq();
        send_byte(8'h2C, ack); chk("R10 glitch not a start", ack, 0);
        scl_m = 1'b1; wq();
        bus_stop();

        // R5: a longer read burst, three bytes from pointer 0x20
        bus_start();
        send_byte(8'h2C, ack);
        send_byte(8'h20, ack);
        bus_start();
        send_byte(8'h2D, ack);
        recv_byte(1'b1, rd); chk("R5 burst byte0", rd, 8'h20 ^ 8'hA5);
        recv_byte(1'b1, rd); chk("R5 burst byte1", rd, 8'h21 ^ 8'hA5);
        recv_byte(1'b0, rd); chk("R5 burst byte2", rd, 8'h22 ^ 8'hA5);
        chk("R6 released after burst", sda_oe, 0);
        bus_stop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule